// File: doc/BRIEF.md
# Predicated Vector Float-to-Integer Converter

This block turns a 128-bit vector of IEEE binary floating-point lanes into integer lanes in one registered step. The vector holds either eight half-precision lanes, each producing a 16-bit integer, or four single-precision lanes, each producing a 32-bit integer. Every operation chooses its own rounding mode and signedness. The block keeps no rounding state between operations.

A 16-bit byte predicate controls the write. Each bit belongs to one byte of the destination. A lane whose predicate bits are all clear is skipped. A lane whose lowest predicate bit is clear, but which has another bit set, is still converted and merged, but it is kept out of the sticky exception flags. Results are merged byte by byte into the old destination value supplied with the request. `done` rises in the cycle after the start strobe.

Top module: `vcvt_f2i`

## Requirements
- R1: `rmode` selects the rounding mode for that operation only: 0 rounds to nearest with ties away from zero, 1 rounds to nearest with ties to even, 2 rounds toward plus infinity and 3 rounds toward minus infinity. No mode is carried over from an earlier operation.
- R2: `uns`=1 produces unsigned integers and `uns`=0 produces two's-complement signed integers.
- R3: `size`=1 means half-precision to 16-bit and `size`=2 means single-precision to 32-bit. A start with `size` 0 or 3 pulses `illegal` in the next cycle, leaves `result` and both flags unchanged, and does not raise `done`.
- R4: Lane e occupies bits [e*W +: W], where W is 16 or 32. Its predicate bits start at bit e*W/8.
- R5: A lane whose predicate bits are all zero keeps its old destination bytes and contributes no flags.
- R6: A lane with predicate bit e*W/8 clear and some other of its bits set is converted and merged, but does not change `flag_inv` or `flag_inx`.
- R7: Result byte k takes the converted value when `mask[k]`=1 and the `dst_old` byte otherwise.
- R8: A value that is out of range after rounding, including infinity, saturates to the largest or smallest integer of the chosen type. For an unsigned result the smallest is 0, and for a signed result it is -2^(W-1). It sets invalid and does not set inexact.
- R9: A NaN converts to 0 and sets invalid. An in-range conversion that discards a nonzero fraction sets inexact.
- R10: `result` is registered. `done` is high for exactly the one cycle after an accepted start, and `result` changes only then.
- R11: Subnormal inputs keep their true value, so they round to 0, +1 or -1 according to the mode, with inexact set.
- R12: `flag_inv` and `flag_inx` are sticky. They accumulate by OR and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request strobe |
| size | input | 2 | Element size code (1 = half, 2 = single) |
| uns | input | 1 | 1 for unsigned results, 0 for signed results |
| rmode | input | 2 | Rounding mode code |
| src | input | 128 | Floating-point source vector |
| dst_old | input | 128 | Prior destination contents |
| mask | input | 16 | Byte predicate |
| result | output | 128 | Merged converted vector |
| flag_inv | output | 1 | Sticky invalid flag |
| flag_inx | output | 1 | Sticky inexact flag |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected size code pulse |

## Verification
The properties assume that `size`, `mask`, `dst_old` and `start` are steady during the cycle in which `start` is sampled. They also assume that `start` is a single-cycle strobe issued away from reset. The bench drives every input on the falling edge and holds it through the next rising edge. It raises `start` for exactly one cycle per request and releases reset on a falling edge. Rounding results are checked against a table of hand-derived vectors that covers every mode, both signs, ties, saturation, NaN, infinity and subnormals.

// File: rtl/vcvt_f2i.sv
module vcvt_f2i (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   size,
  input  logic         uns,
  input  logic [1:0]   rmode,
  input  logic [127:0] src,
  input  logic [127:0] dst_old,
  input  logic [15:0]  mask,
  output logic [127:0] result,
  output logic         flag_inv,
  output logic         flag_inx,
  output logic         done,
  output logic         illegal
);

  // returns {invalid, inexact, value[31:0]}
  function automatic logic [33:0] conv(input logic [31:0] x, input logic half,
                                       input logic un, input logic [1:0] rm);
    logic         sgn, allone, nan_i, inf_i, big, rup, ovf, g, st;
    logic [7:0]   ef;
    logic [22:0]  mf;
    logic [23:0]  mant;
    logic [111:0] q;
    logic [31:0]  ip, v;
    logic [32:0]  mag, lim, m2;
    int           e, sh;
    sgn    = half ? x[15] : x[31];
    ef     = half ? {3'b0, x[14:10]} : x[30:23];
    mf     = half ? {x[9:0], 13'b0} : x[22:0];
    allone = half ? (ef == 8'd31) : (ef == 8'd255);
    nan_i  = allone && (mf != 23'd0);
    inf_i  = allone && (mf == 23'd0);
    mant   = {ef != 8'd0, mf};
    e      = (ef == 8'd0 ? 1 : int'(ef)) - (half ? 15 : 127);
    sh     = 31 - e;
    big    = sh < 0;
    ip = '0; g = 1'b0; st = 1'b0; q = '0;
    if (!big && sh <= 88) begin
      q  = {mant, 88'b0} >> sh;
      ip = q[111:80];
      g  = q[79];
      st = |q[78:0];
    end else if (!big) begin
      st = |mant;
    end
    case (rm)
      2'd0:    rup = g;
      2'd1:    rup = g & (st | ip[0]);
      2'd2:    rup = ~sgn & (g | st);
      default: rup = sgn & (g | st);
    endcase
    mag = {1'b0, ip} + {32'b0, rup};
    if (un)
      lim = sgn ? 33'd0 : (half ? 33'h0_0000_FFFF : 33'h0_FFFF_FFFF);
    else if (half)
      lim = sgn ? 33'h0_0000_8000 : 33'h0_0000_7FFF;
    else
      lim = sgn ? 33'h0_8000_0000 : 33'h0_7FFF_FFFF;
    ovf = inf_i | big | (mag > lim);
    m2  = ovf ? lim : mag;
    v   = sgn ? (32'd0 - m2[31:0]) : m2[31:0];
    if (nan_i)    return {1'b1, 1'b0, 32'd0};
    else if (ovf) return {1'b1, 1'b0, v};
    else          return {1'b0, g | st, v};
  endfunction

  logic         legal;
  logic [127:0] nxt;
  logic         inv_n, inx_n;

  assign legal = size[0] ^ size[1];

  always_comb begin
    logic [33:0] c;
    nxt   = dst_old;
    inv_n = 1'b0;
    inx_n = 1'b0;
    if (size == 2'd1) begin
      for (int i = 0; i < 8; i++) begin
        c = conv({16'b0, src[16*i +: 16]}, 1'b1, uns, rmode);
        for (int b = 0; b < 2; b++)
          if (mask[2*i+b]) nxt[16*i+8*b +: 8] = c[8*b +: 8];
        if (mask[2*i]) begin
          inv_n = inv_n | c[33];
          inx_n = inx_n | c[32];
        end
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        c = conv(src[32*i +: 32], 1'b0, uns, rmode);
        for (int b = 0; b < 4; b++)
          if (mask[4*i+b]) nxt[32*i+8*b +: 8] = c[8*b +: 8];
        if (mask[4*i]) begin
          inv_n = inv_n | c[33];
          inx_n = inx_n | c[32];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      flag_inv <= 1'b0;
      flag_inx <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      done    <= start & legal;
      illegal <= start & ~legal;
      if (start && legal) begin
        result   <= nxt;
        flag_inv <= flag_inv | inv_n;
        flag_inx <= flag_inx | inx_n;
      end
    end
  end

endmodule

// File: rtl/vcvt_f2i_checker.sv
module vcvt_f2i_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   size,
  input logic         uns,
  input logic [1:0]   rmode,
  input logic [127:0] src,
  input logic [127:0] dst_old,
  input logic [15:0]  mask,
  input logic [127:0] result,
  input logic         flag_inv,
  input logic         flag_inx,
  input logic         done,
  input logic         illegal
);
  logic ok_size;
  assign ok_size = (size == 2'd1) || (size == 2'd2);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && ok_size |=> done && !illegal); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(result)); // R10
  AST_BAD_SIZE_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ok_size |=> illegal && !done && $stable(result) && $stable(flag_inv) && $stable(flag_inx)); // R3
  AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |=> flag_inv); // R12
  AST_INX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inx |=> flag_inx); // R12
  AST_EMPTY_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    start && ok_size && mask == 16'd0 |=> result == $past(dst_old) && $stable(flag_inv) && $stable(flag_inx)); // R5
endmodule

bind vcvt_f2i vcvt_f2i_checker chk (.*);

// File: tb/vcvt_f2i_test.sv
module vcvt_f2i_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, uns = 1'b0;
  logic [1:0] size = 2'd2, rmode = 2'd0;
  logic [127:0] src = '0, dst_old = '0;
  logic [15:0] mask = '0;
  logic [127:0] result;
  logic flag_inv, flag_inx, done, illegal;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  vcvt_f2i uut (.*);

  always #10 clk = ~clk;

  // {size, uns, rmode, float, expected, inv, inx}
  localparam int NV = 29;
  localparam logic [70:0] VEC [NV] = '{
    {2'd2,1'b0,2'd0,32'h40200000,32'h00000003,1'b0,1'b1},
    {2'd2,1'b0,2'd1,32'h40200000,32'h00000002,1'b0,1'b1},
    {2'd2,1'b0,2'd1,32'hC0200000,32'hFFFFFFFE,1'b0,1'b1},
    {2'd2,1'b0,2'd0,32'hC0200000,32'hFFFFFFFD,1'b0,1'b1},
    {2'd2,1'b0,2'd2,32'hBFC00000,32'hFFFFFFFF,1'b0,1'b1},
    {2'd2,1'b0,2'd3,32'hBFC00000,32'hFFFFFFFE,1'b0,1'b1},
    {2'd2,1'b0,2'd2,32'h3FC00000,32'h00000002,1'b0,1'b1},
    {2'd2,1'b0,2'd3,32'h3FC00000,32'h00000001,1'b0,1'b1},
    {2'd2,1'b0,2'd1,32'h3FC00000,32'h00000002,1'b0,1'b1},
    {2'd2,1'b1,2'd1,32'h4F32D05E,32'hB2D05E00,1'b0,1'b0},
    {2'd2,1'b0,2'd1,32'h4F32D05E,32'h7FFFFFFF,1'b1,1'b0},
    {2'd2,1'b1,2'd1,32'hBF800000,32'h00000000,1'b1,1'b0},
    {2'd2,1'b1,2'd2,32'hBF000000,32'h00000000,1'b0,1'b1},
    {2'd2,1'b1,2'd3,32'hBF000000,32'h00000000,1'b1,1'b0},
    {2'd2,1'b0,2'd1,32'h7FC00000,32'h00000000,1'b1,1'b0},
    {2'd2,1'b0,2'd1,32'h7F800000,32'h7FFFFFFF,1'b1,1'b0},
    {2'd2,1'b0,2'd3,32'hCF000000,32'h80000000,1'b0,1'b0},
    {2'd2,1'b0,2'd1,32'h4F000000,32'h7FFFFFFF,1'b1,1'b0},
    {2'd2,1'b0,2'd2,32'h00000001,32'h00000001,1'b0,1'b1},
    {2'd2,1'b0,2'd3,32'h80000001,32'hFFFFFFFF,1'b0,1'b1},
    {2'd2,1'b0,2'd1,32'h00000001,32'h00000000,1'b0,1'b1},
    {2'd1,1'b0,2'd0,32'h00004100,32'h00000003,1'b0,1'b1},
    {2'd1,1'b0,2'd1,32'h0000C100,32'h0000FFFE,1'b0,1'b1},
    {2'd1,1'b1,2'd1,32'h00007BFF,32'h0000FFE0,1'b0,1'b0},
    {2'd1,1'b0,2'd1,32'h00007BFF,32'h00007FFF,1'b1,1'b0},
    {2'd1,1'b0,2'd2,32'h00000001,32'h00000001,1'b0,1'b1},
    {2'd1,1'b0,2'd3,32'h00003800,32'h00000000,1'b0,1'b1},
    {2'd1,1'b1,2'd3,32'h00007E00,32'h00000000,1'b1,1'b0},
    {2'd1,1'b0,2'd3,32'h0000B800,32'h0000FFFF,1'b0,1'b1}
  };

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic run_op(input logic [1:0] sz, input logic u, input logic [1:0] rm,
                        input logic [127:0] s, input logic [127:0] d, input logic [15:0] m);
    @(negedge clk);
    size = sz; uns = u; rmode = rm; src = s; dst_old = d; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    do_reset();
    check("R10 reset result", result, '0);
    check("R12 reset flags", {126'd0, flag_inv, flag_inx}, '0);
    check("R10 reset done/illegal", {126'd0, done, illegal}, '0);

    // R1 R2 R8 R9 R11: rounding table, broadcast to all lanes
    for (int i = 0; i < NV; i++) begin
      logic [127:0] s, ex;
      do_reset();
      if (VEC[i][70:69] == 2'd1) begin
        s  = {8{VEC[i][49:34]}};
        ex = {8{VEC[i][17:2]}};
      end else begin
        s  = {4{VEC[i][65:34]}};
        ex = {4{VEC[i][33:2]}};
      end
      run_op(VEC[i][70:69], VEC[i][68], VEC[i][67:66], s, {8{16'h5A5A}}, 16'hFFFF);
      check($sformatf("R1 R2 R8 R9 R11 vec %0d result", i), result, ex);
      check($sformatf("R8 R9 vec %0d flags", i), {126'd0, flag_inv, flag_inx}, {126'd0, VEC[i][1:0]});
      check($sformatf("R10 vec %0d done", i), {127'd0, done}, 128'd1);
    end

    // R10: done lasts one cycle
    @(negedge clk);
    check("R10 done single cycle", {127'd0, done}, '0);

    // R4 R5 R6 R7: lane placement and byte merge, single precision
    do_reset();
    run_op(2'd2, 1'b0, 2'd1,
           {32'h7FC00000, 32'hBF800000, 32'h40200000, 32'h3F800000},
           {16{8'hAA}}, 16'h20EF);
    check("R4 R5 R6 R7 merged result", result,
          {32'hAAAA00AA, 32'hAAAAAAAA, 32'h000000AA, 32'h00000001});
    check("R6 partial lanes raise no flags", {126'd0, flag_inv, flag_inx}, '0);

    // R12: flags accumulate, then stay set through an exact conversion
    run_op(2'd2, 1'b0, 2'd1,
           {32'h7FC00000, 32'hBF800000, 32'h40200000, 32'h3F800000},
           '0, 16'hFFFF);
    check("R9 full mask flags", {126'd0, flag_inv, flag_inx}, 128'd3);
    run_op(2'd2, 1'b0, 2'd1, {4{32'h3F800000}}, '0, 16'hFFFF);
    check("R12 flags sticky", {126'd0, flag_inv, flag_inx}, 128'd3);
    check("R12 exact op result", result, {4{32'h00000001}});

    // R4: half-precision lanes hold values 0..7
    run_op(2'd1, 1'b0, 2'd0,
           {16'h4700, 16'h4600, 16'h4500, 16'h4400, 16'h4200, 16'h4000, 16'h3C00, 16'h0000},
           '0, 16'hFFFF);
    check("R4 half lane order", result,
          {16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0});

    // R5: all-zero mask keeps destination
    run_op(2'd1, 1'b0, 2'd0, {8{16'h4100}}, {16{8'h3C}}, 16'h0000);
    check("R5 empty mask result", result, {16{8'h3C}});

    // R3: illegal sizes
    held = result;
    do_reset();
    run_op(2'd2, 1'b0, 2'd1, {4{32'h40200000}}, '0, 16'hFFFF);
    held = result;
    run_op(2'd0, 1'b0, 2'd1, {4{32'h7FC00000}}, '1, 16'hFFFF);
    check("R3 size0 illegal/done", {126'd0, illegal, done}, 128'd2);
    check("R3 size0 result kept", result, held);
    check("R3 size0 flags kept", {126'd0, flag_inv, flag_inx}, 128'd1);
    run_op(2'd3, 1'b0, 2'd1, {4{32'h7FC00000}}, '1, 16'hFFFF);
    check("R3 size3 illegal/done", {126'd0, illegal, done}, 128'd2);
    check("R3 size3 result kept", result, held);
    @(negedge clk);
    check("R3 illegal single cycle", {127'd0, illegal}, '0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule